// File: doc/BRIEF.md
# Atomic Compare-and-Swap Word Store

This block is a small on-chip word array that several requesters share through one atomic request port. Each requester presents an operation, an address and two data words. A round-robin arbiter picks one requester per cycle. In that same cycle the unit reads the addressed word, decides whether to update it, and writes the result. No other access to the array can fall between the read and the write.

Four operations exist. A plain read returns the word. A plain write stores a new word. A compare-and-swap stores the new word only when the current word equals the expected word. A tagged compare-and-swap treats the low half of each word as an index and the high half as a version counter. It compares the whole word, and on a match it stores the new index with the counter advanced by one. A location whose index returns to an earlier value therefore no longer matches a stale expected word.

Every reply carries a success flag, the requester number and the word as it was before the operation. After a failed swap, a requester can reload its expected copy from that prior word.

Top module: `cas_mem_unit`

## Requirements
- R1: After reset every entry reads as zero and resp_valid is low.
- R2: A CAS (op code 2) whose expected word equals the stored word writes the new word and replies with resp_success = 1.
- R3: A CAS or tagged CAS whose expected word differs from the stored word leaves the entry unchanged and replies with resp_success = 0.
- R4: resp_old always holds the word that was stored before the operation, whatever the operation and its outcome. After a failed compare, this is the current content the requester needs to refresh its expected copy.
- R5: A tagged CAS (op code 3) compares all bits of the word. On a match it stores {stored counter + 1, new index}, where the index is the low half ([DW/2-1:0]) of the new word and the counter is the high half of the stored word.
- R6: The tagged counter wraps from all-ones to zero, and the index is stored as given.
- R7: In tagged mode, a location whose index has left a value and come back to it fails a CAS that uses the earlier expected word, because its counter has moved on.
- R8: The response (resp_valid, resp_id, resp_success, resp_old) appears exactly one cycle after the clock edge at which the request was granted, and resp_id names the granted requester.
- R9: At most one req_ready is high in a cycle, only for a requester whose req_valid is high. Among waiting requesters, the grant goes to the first one found after the last granted number, counting upward and wrapping round.
- R10: A plain read (op code 0) leaves the entry unchanged and replies with success = 1. A plain write (op code 1) stores the new word and replies with success = 1. Both serialize with swaps in grant order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_ready | output | NREQ | Grant; the request is taken at the clock edge where valid and ready are both high |
| req_op | input | 2*NREQ | Operation per requester: 0 read, 1 write, 2 CAS, 3 tagged CAS |
| req_addr | input | AW*NREQ | Word address per requester |
| req_expect | input | DW*NREQ | Expected word per requester |
| req_new | input | DW*NREQ | New word (or new index in its low half) per requester |
| resp_valid | output | 1 | Reply present for one cycle |
| resp_id | output | IW | Number of the requester being answered |
| resp_success | output | 1 | Swap or access took effect |
| resp_old | output | DW | Word stored before the operation |

## Verification
On every cycle, the assertions check that grants are one-hot and only go to valid requesters. They also check that each reply follows a grant, that an entry not addressed by a write keeps its value, and that a swap's success flag agrees with the comparison of its prior word against the recorded expected word. Only the bench's scenarios can show what the stored words actually become. These cover the counter increment and its wrap, the stale-index failure after an index goes away and comes back, the refresh value after a miss, and the round-robin order when all requesters contend at once.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_CAS  = 2'd2,
    OP_TCAS = 2'd3
  } cas_op_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (!gnt_any && req[j]) begin
        gnt_any = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (gnt_any) ptr_d = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (gnt_any) ptr_q <= ptr_d;
  end

  // R9: a single grant per cycle, only to an asking requester
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));
endmodule

// File: rtl/cas_alu.sv
module cas_alu
  import cas_pkg::*;
#(
  parameter int DW = 32,
  localparam int HW = DW / 2,
  localparam int CW = DW - HW
) (
  input  cas_op_e         op,
  input  logic [DW-1:0]   cur,
  input  logic [DW-1:0]   expect_w,
  input  logic [DW-1:0]   new_w,
  output logic            wr_en,
  output logic [DW-1:0]   wr_data,
  output logic            success
);
  localparam logic [CW-1:0] CTR_ONE = CW'(1);
  logic hit;

  always_comb begin
    hit     = (cur == expect_w);
    wr_en   = 1'b0;
    wr_data = new_w;
    success = 1'b1;
    unique case (op)
      OP_RD:   wr_en = 1'b0;
      OP_WR:   wr_en = 1'b1;
      OP_CAS: begin
        wr_en   = hit;
        success = hit;
      end
      OP_TCAS: begin
        wr_en   = hit;
        success = hit;
        wr_data = {cur[DW-1:HW] + CTR_ONE, new_w[HW-1:0]};
      end
      default: wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_hold
    // R3 / R10: an entry not targeted by a write keeps its word
    a_r3_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (addr == AW'(g))) |=> $stable(mem[g]));
  end
endmodule

// File: rtl/cas_mem_unit.sv
module cas_mem_unit
  import cas_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  output logic [NREQ-1:0]    req_ready,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_expect,
  input  logic [DW*NREQ-1:0] req_new,
  output logic               resp_valid,
  output logic [IW-1:0]      resp_id,
  output logic               resp_success,
  output logic [DW-1:0]      resp_old
);
  logic [IW-1:0] gnt_idx;
  logic          gnt_any;
  cas_op_e       sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_exp, sel_new, cur_w, wr_data;
  logic          wr_en, ok;

  rr_arbiter #(.N(NREQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(req_ready), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  always_comb begin
    sel_op   = cas_op_e'(req_op[gnt_idx*2 +: 2]);
    sel_addr = req_addr[gnt_idx*AW +: AW];
    sel_exp  = req_expect[gnt_idx*DW +: DW];
    sel_new  = req_new[gnt_idx*DW +: DW];
  end

  word_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(sel_addr),
    .we(wr_en && gnt_any), .wdata(wr_data), .rdata(cur_w)
  );

  cas_alu #(.DW(DW)) u_alu (
    .op(sel_op), .cur(cur_w), .expect_w(sel_exp), .new_w(sel_new),
    .wr_en(wr_en), .wr_data(wr_data), .success(ok)
  );

  // response next-state and register
  logic          rv_d, rs_d;
  logic [IW-1:0] rid_d;
  logic [DW-1:0] rold_d;

  always_comb begin
    rv_d   = gnt_any;
    rid_d  = resp_id;
    rs_d   = resp_success;
    rold_d = resp_old;
    if (gnt_any) begin
      rid_d  = gnt_idx;
      rs_d   = ok;
      rold_d = cur_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_id      <= '0;
      resp_success <= 1'b0;
      resp_old     <= '0;
    end else begin
      resp_valid <= rv_d;
      if (gnt_any) begin
        resp_id      <= rid_d;
        resp_success <= rs_d;
        resp_old     <= rold_d;
      end
    end
  end

  // checker state: what was granted, kept apart from the datapath
  cas_op_e       chk_op;
  logic [DW-1:0] chk_exp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_op  <= OP_RD;
      chk_exp <= '0;
    end else if (gnt_any) begin
      chk_op  <= cas_op_e'(req_op[gnt_idx*2 +: 2]);
      chk_exp <= req_expect[gnt_idx*DW +: DW];
    end
  end

  // R8: a reply only follows a grant one cycle earlier
  a_r8_resp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(gnt_any));

  // R2 / R3: swap verdict matches prior word against expected word
  a_r2_swap_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (chk_op == OP_CAS || chk_op == OP_TCAS))
      |-> (resp_success == (resp_old == chk_exp)));

  // R10: plain accesses always report success
  a_r10_plain_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (chk_op == OP_RD || chk_op == OP_WR)) |-> resp_success);
endmodule

// File: tb/cas_mem_unit_test.sv
module cas_mem_unit_test;
  localparam int NREQ = 4, DEPTH = 16, DW = 32, AW = 4, IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]    req_valid = '0;
  logic [NREQ-1:0]    req_ready;
  logic [2*NREQ-1:0]  req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_expect = '0;
  logic [DW*NREQ-1:0] req_new = '0;
  logic               resp_valid, resp_success;
  logic [IW-1:0]      resp_id;
  logic [DW-1:0]      resp_old;

  always #5 clk = ~clk;

  cas_mem_unit #(.NREQ(NREQ), .DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_expect(req_expect),
    .req_new(req_new), .resp_valid(resp_valid), .resp_id(resp_id),
    .resp_success(resp_success), .resp_old(resp_old)
  );

  typedef struct {
    int          id;
    logic        ok;
    logic [31:0] old;
    string       rq;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mdl [DEPTH];
  int          checks = 0, fails = 0;
  int          last_gnt = NREQ - 1;
  bit          done = 1'b0;

  task automatic fail_line(string rq, string what, logic [31:0] act, logic [31:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
  endtask

  // model update and expected reply, from the requirements
  function automatic exp_t predict(int k, logic [1:0] op, int a,
                                   logic [31:0] e, logic [31:0] n, string rq);
    exp_t x;
    x.id = k; x.old = mdl[a]; x.rq = rq; x.ok = 1'b1;
    case (op)
      2'd1: mdl[a] = n;
      2'd2: begin x.ok = (mdl[a] == e); if (x.ok) mdl[a] = n; end
      2'd3: begin
        x.ok = (mdl[a] == e);
        if (x.ok) mdl[a] = {mdl[a][31:16] + 16'd1, n[15:0]};
      end
      default: ;
    endcase
    return x;
  endfunction

  task automatic load(int k, logic [1:0] op, int a, logic [31:0] e, logic [31:0] n);
    req_op[k*2 +: 2]      = op;
    req_addr[k*AW +: AW]  = AW'(a);
    req_expect[k*DW +: DW] = e;
    req_new[k*DW +: DW]   = n;
  endtask

  // single request from requester k; starts at a negedge
  task automatic issue(int k, logic [1:0] op, int a, logic [31:0] e,
                       logic [31:0] n, string rq);
    load(k, op, a, e, n);
    req_valid[k] = 1'b1;
    forever begin
      #1;
      if (req_ready[k]) break;
      @(negedge clk);
    end
    sb.push_back(predict(k, op, a, e, n, rq));
    last_gnt = k;
    @(negedge clk);
    req_valid[k] = 1'b0;
    checks++;  // R8: reply one cycle after the grant, naming the requester
    if (!(resp_valid && int'(resp_id) == k))
      fail_line("R8", "reply timing/id", {31'd0, resp_valid}, 32'd1);
  endtask

  // all requesters ask at once; grants must follow round-robin order (R9)
  task automatic contend(int base_a);
    int pend = NREQ;
    for (int k = 0; k < NREQ; k++) load(k, 2'd0, base_a + k, 0, 0);
    req_valid = '1;
    while (pend > 0) begin
      int want, got;
      #1;
      want = (last_gnt + 1) % NREQ;
      while (!req_valid[want]) want = (want + 1) % NREQ;
      got = -1;
      for (int k = 0; k < NREQ; k++) if (req_ready[k]) got = k;
      checks++;
      if ($countones(req_ready) != 1 || got != want)
        fail_line("R9", "grant order", 32'(got), 32'(want));
      if (got >= 0) begin
        sb.push_back(predict(got, 2'd0, base_a + got, 0, 0, "R9"));
        last_gnt = got;
        @(negedge clk);
        req_valid[got] = 1'b0;
      end else begin
        @(negedge clk);
      end
      pend--;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fail_line("R8", "unexpected reply", resp_old, 32'd0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (int'(resp_id) != x.id || resp_success !== x.ok || resp_old !== x.old) begin
          fail_line(x.rq, "reply id", 32'(resp_id), 32'(x.id));
          $display("FAIL %s success/old: actual %0b/%h expected %0b/%h",
                   x.rq, resp_success, resp_old, x.ok, x.old);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1: no reply after reset
    if (resp_valid !== 1'b0) fail_line("R1", "resp_valid", {31'd0, resp_valid}, 32'd0);
    issue(0, 2'd0, 0, 0, 0, "R1");
    issue(1, 2'd0, 3, 0, 0, "R1");
    issue(2, 2'd0, 15, 0, 0, "R1");

    // R10 plain write and read
    issue(3, 2'd1, 5, 0, 32'h1111_AAAA, "R10");
    issue(0, 2'd0, 5, 0, 0, "R10");
    // R2 matching swap, then read back
    issue(1, 2'd2, 5, 32'h1111_AAAA, 32'h2222_BBBB, "R2");
    issue(2, 2'd0, 5, 0, 0, "R2");
    // R3 / R4 stale swap fails, returns current word, entry unchanged
    issue(3, 2'd2, 5, 32'h1111_AAAA, 32'h3333_CCCC, "R4");
    issue(0, 2'd0, 5, 0, 0, "R3");

    // R5 tagged swaps on entry 7
    issue(1, 2'd1, 7, 0, 32'h0000_00AA, "R5");
    issue(2, 2'd3, 7, 32'h0000_00AA, 32'h0000_00BB, "R5");
    issue(3, 2'd0, 7, 0, 0, "R5");
    issue(0, 2'd3, 7, 32'h0001_00BB, 32'h0000_00AA, "R5");
    // R7 index is back to AA, but the stale expected word fails
    issue(1, 2'd3, 7, 32'h0000_00AA, 32'h0000_00CC, "R7");
    issue(2, 2'd0, 7, 0, 0, "R7");
    // plain swap on the same pattern is fooled (contrast for R7)
    issue(3, 2'd1, 8, 0, 32'h0000_00AA, "R2");
    issue(0, 2'd2, 8, 32'h0000_00AA, 32'h0000_00BB, "R2");
    issue(1, 2'd2, 8, 32'h0000_00BB, 32'h0000_00AA, "R2");
    issue(2, 2'd2, 8, 32'h0000_00AA, 32'h0000_00DD, "R2");

    // R6 counter wraps
    issue(3, 2'd1, 9, 0, 32'hFFFF_0011, "R6");
    issue(0, 2'd3, 9, 32'hFFFF_0011, 32'h1234_0022, "R6");
    issue(1, 2'd0, 9, 0, 0, "R6");

    // R9 contention twice, at different starting points
    contend(0);
    issue(2, 2'd0, 1, 0, 0, "R9");
    contend(4);

    // R10 write does not disturb a neighbour entry
    issue(3, 2'd1, 10, 0, 32'hDEAD_BEEF, "R10");
    issue(0, 2'd0, 11, 0, 0, "R10");
    issue(1, 2'd0, 10, 0, 0, "R10");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) fail_line("R8", "missing replies", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule